// File: doc/BRIEF.md
# Strap-Latched Frequency Select and Output Gating Controller

This block sits between a small configuration register bank and the clock output drivers of a clock generator. During reset it samples three frequency-select strap pins. The same pins carry reference clocks in normal operation, so the block releases them to their output drivers once reset ends. A register bit chooses the frequency-select code the synthesizer uses. The code comes either from the captured straps or from a software-written field.

For each output group (PCI, HTT, USB, REF, CPU pairs, SRC pair) the block combines the per-output enable bits, the power-down input and the frequency code. From these it produces a run/stop signal for each output and a drive-enable signal for each group. A run signal only changes in a cycle where that group's clock is reported to be in its low phase, so stopping an output never cuts a pulse short. The block also merges the spread-spectrum pin with the register spread bits. It drives the oscillator and VCO enables, and it passes programmed PLL M/N values on only while their enable bit is set.

Top module: `clkout_ctl`

## Requirements
- R1: While `rst_n` is low, `strap_in` is sampled every cycle and `strap_oe` is 0. From the first clock after release, `strap_oe` is 1 and the captured value stays frozen, whatever `strap_in` does later.
- R2: Register 0 holds bit 7 = software-select, bit 6 = CPU spread, bit 5 = SRC spread, and bits 3:0 = software code. After reset, bit 7 and bit 3 are 0 and bits 2:0 equal the captured straps. `fs_code` is bits 3:0 when bit 7 is 1, and `{0, captured straps}` when bit 7 is 0.
- R3: When `fs_code` is 0000, `pci_oe`, `htt_oe` and `cpu_oe` are 0 (high impedance). For any other code they are 1.
- R4: Register 1 holds the PCI enables in bits 3:0 and the HTT enables in bits 7:4. Register 2 holds the USB enables in bits 1:0, the REF enables in bits 3:2 and the CPU pair enables in bits 7:4. All of these bits reset to 1. A cleared bit drives that output's run bit to 0 (held low) and leaves the group's drive enable unchanged.
- R5: A stopped CPU pair (`cpu_run` bit 0 with `cpu_oe` 1) is parked with true low and complement high. The CPU run bits follow register 2 bits 7:4 in the same way as R4.
- R6: Register 3 holds bit 0 = SRC enable (reset 1) and bit 1 = SRC float-in-power-down (reset 0). `src_oe` is 0 when the SRC enable is 0. During power-down, `src_oe` is the inverse of bit 1 and `src_run` is 0.
- R7: `spread_pin` passes through a two-flop synchroniser. `cpu_ss_on` = synchronised pin OR register 0 bit 6, and `src_ss_on` = synchronised pin OR register 0 bit 5. A pin change appears at the outputs after two rising edges.
- R8: `pd_n` is asynchronous and passes through a two-flop synchroniser. Two edges after `pd_n` falls, `osc_en` and `vco_en` are both 0, and every run bit is 0 one edge later (given a low phase). When power returns, `osc_en` rises first and `vco_en` rises one cycle after it.
- R9: Register 4 bit 0 (reset 0) is the M/N pass enable and appears on `mn_en`. Registers 5/6/7 hold the CPU M (bits 5:0), N low byte and N bits 9:8 (in bits 1:0). Registers 8/9/10 hold the same fields for SRC. The M/N outputs show these values only while the enable is 1 and are 0 otherwise.
- R10: A run bit changes only at a rising edge where its group's `grp_low` bit is 1. The group index is 0 PCI, 1 HTT, 2 USB, 3 REF, 4 CPU, 5 SRC. While that bit is 0 the run bits hold, and writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_in | input | 3 | Frequency-select strap levels |
| strap_oe | output | 1 | Releases shared strap pins to their clock drivers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pd_n | input | 1 | Asynchronous active-low power-down |
| spread_pin | input | 1 | Asynchronous spread force, active high |
| grp_low | input | 6 | Per-group clock low-phase indication |
| fs_code | output | 4 | Effective frequency-select code |
| pci_run | output | 4 | PCI outputs running |
| pci_oe | output | 1 | PCI group driven (0 = high impedance) |
| htt_run | output | 4 | HTT outputs running |
| htt_oe | output | 1 | HTT group driven |
| usb_run | output | 2 | USB outputs running |
| ref_run | output | 2 | REF outputs running |
| cpu_run | output | 4 | CPU pairs running (stopped = true 0, complement 1) |
| cpu_oe | output | 1 | CPU group driven |
| src_run | output | 1 | SRC pair running |
| src_oe | output | 1 | SRC pair driven |
| cpu_ss_on | output | 1 | CPU PLL spread on |
| src_ss_on | output | 1 | SRC PLL spread on |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |
| mn_en | output | 1 | M/N values valid for the PLLs |
| cpu_m | output | 6 | CPU PLL M value |
| cpu_n | output | 10 | CPU PLL N value |
| src_m | output | 6 | SRC PLL M value |
| src_n | output | 10 | SRC PLL N value |

## Verification
A wrong strap capture shows on `fs_code` from the first cycle after reset and stays there, because nothing refreshes the latch. A wrong enable or power-down term shows on a run bit one edge after the next low phase of its group. A held low phase therefore hides the error until the bench lets that group's indication rise. Errors in the synchronisers show as a run bit or enable that moves one cycle early or late against the exact edge counts of R7 and R8. For that reason the bench samples those paths at each edge and does not wait for them to settle.

// File: rtl/clkctl_pkg.sv
// Shared constants and the decoded configuration record for the clock
// output controller. Assumes one register bank of eleven bytes.
package clkctl_pkg;

    localparam int STRAP_W  = 3;
    localparam int FS_W     = 4;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int M_W      = 6;
    localparam int N_W      = 10;
    localparam int N_PCI    = 4;
    localparam int N_HTT    = 4;
    localparam int N_USB    = 2;
    localparam int N_REF    = 2;
    localparam int N_CPU    = 4;
    localparam int N_SRC    = 1;
    localparam int NUM_GRP  = 6;

    // Outputs per group, indexed by group number.
    localparam int GRP_W [NUM_GRP] = '{N_PCI, N_HTT, N_USB, N_REF, N_CPU, N_SRC};

    localparam int G_PCI = 0;
    localparam int G_HTT = 1;
    localparam int G_USB = 2;
    localparam int G_REF = 3;
    localparam int G_CPU = 4;
    localparam int G_SRC = 5;

    localparam logic [ADDR_W-1:0] A_FREQ   = 4'd0;
    localparam logic [ADDR_W-1:0] A_SE_EN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_AUX_EN = 4'd2;
    localparam logic [ADDR_W-1:0] A_SRC    = 4'd3;
    localparam logic [ADDR_W-1:0] A_PLL    = 4'd4;
    localparam logic [ADDR_W-1:0] A_CPU_M  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CPU_NL = 4'd6;
    localparam logic [ADDR_W-1:0] A_CPU_NH = 4'd7;
    localparam logic [ADDR_W-1:0] A_SRC_M  = 4'd8;
    localparam logic [ADDR_W-1:0] A_SRC_NL = 4'd9;
    localparam logic [ADDR_W-1:0] A_SRC_NH = 4'd10;

    // First bit of a group inside the flat run vector.
    function automatic int grp_base(input int g);
        int s;
        s = 0;
        for (int i = 0; i < g; i++) s += GRP_W[i];
        return s;
    endfunction

    localparam int RUN_W = N_PCI + N_HTT + N_USB + N_REF + N_CPU + N_SRC;

    typedef struct packed {
        logic              fs_sw_src;
        logic              cpu_ss;
        logic              src_ss;
        logic [FS_W-1:0]   fs_sw;
        logic [N_PCI-1:0]  pci_en;
        logic [N_HTT-1:0]  htt_en;
        logic [N_USB-1:0]  usb_en;
        logic [N_REF-1:0]  ref_en;
        logic [N_CPU-1:0]  cpu_en;
        logic              src_en;
        logic              src_pd_float;
        logic              mn_en;
        logic [M_W-1:0]    cpu_m;
        logic [N_W-1:0]    cpu_n;
        logic [M_W-1:0]    src_m;
        logic [N_W-1:0]    src_n;
    } cfg_t;

endpackage

// File: rtl/sync_cell.sv
// Multi-flop synchroniser for a single asynchronous level.
// Assumes STAGES >= 2; the chain resets to RST_VAL.
module sync_cell #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
// Captures the strap levels on every reset cycle and freezes them at
// release; then hands the shared pins over to their output drivers.
// Assumes straps are stable for the last reset cycle.
module strap_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] lat_q,
    output logic         drv_q
);
    // Track pins during reset, hold afterwards; drive pins after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= strap_in;
            drv_q <= 1'b0;
        end else begin
            drv_q <= 1'b1;
        end
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(lat_q)); // R1
    AST_STRAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> drv_q); // R1
endmodule

// File: rtl/ctl_regs.sv
// Configuration register bank: write-only byte port decoded into the
// configuration record. Unmapped addresses and unused bits are dropped.
// The frequency field loads the strap pins during reset, like the latch.
module ctl_regs
    import clkctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output cfg_t               cfg
);
    // Reset defaults and byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg              <= '0;
            cfg.fs_sw        <= {1'b0, strap_in};
            cfg.pci_en       <= '1;
            cfg.htt_en       <= '1;
            cfg.usb_en       <= '1;
            cfg.ref_en       <= '1;
            cfg.cpu_en       <= '1;
            cfg.src_en       <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                A_FREQ: begin
                    cfg.fs_sw_src <= wr_data[7];
                    cfg.cpu_ss    <= wr_data[6];
                    cfg.src_ss    <= wr_data[5];
                    cfg.fs_sw     <= wr_data[FS_W-1:0];
                end
                A_SE_EN: begin
                    cfg.pci_en <= wr_data[N_PCI-1:0];
                    cfg.htt_en <= wr_data[4 +: N_HTT];
                end
                A_AUX_EN: begin
                    cfg.usb_en <= wr_data[N_USB-1:0];
                    cfg.ref_en <= wr_data[2 +: N_REF];
                    cfg.cpu_en <= wr_data[4 +: N_CPU];
                end
                A_SRC: begin
                    cfg.src_en       <= wr_data[0];
                    cfg.src_pd_float <= wr_data[1];
                end
                A_PLL:    cfg.mn_en <= wr_data[0];
                A_CPU_M:  cfg.cpu_m <= wr_data[M_W-1:0];
                A_CPU_NL: cfg.cpu_n[7:0] <= wr_data;
                A_CPU_NH: cfg.cpu_n[N_W-1:8] <= wr_data[N_W-9:0];
                A_SRC_M:  cfg.src_m <= wr_data[M_W-1:0];
                A_SRC_NL: cfg.src_n[7:0] <= wr_data;
                A_SRC_NH: cfg.src_n[N_W-1:8] <= wr_data[N_W-9:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/out_gate.sv
// Run/stop register for one output group. A new run value is taken only
// in a cycle where the group's clock is in its low phase, so a stop or
// start never truncates a pulse. Assumes phase_low is already synchronous.
module out_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_low,
    input  logic [N-1:0] want,
    output logic [N-1:0] run_q
);
    // Update the run bits only in the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (phase_low) run_q <= want;
    end

    AST_RUN_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != $past(run_q)) |-> $past(phase_low)); // R10
endmodule

// File: rtl/clkout_ctl.sv
// Top of the strap-latched frequency and output controller. Combines the
// captured straps, the register bank, power-down and spread pins into
// per-output run bits, per-group drive enables and PLL controls.
// Assumes pd_n and spread_pin are asynchronous; grp_low is synchronous.
module clkout_ctl
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               strap_oe,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               pd_n,
    input  logic               spread_pin,
    input  logic [NUM_GRP-1:0] grp_low,
    output logic [FS_W-1:0]    fs_code,
    output logic [N_PCI-1:0]   pci_run,
    output logic               pci_oe,
    output logic [N_HTT-1:0]   htt_run,
    output logic               htt_oe,
    output logic [N_USB-1:0]   usb_run,
    output logic [N_REF-1:0]   ref_run,
    output logic [N_CPU-1:0]   cpu_run,
    output logic               cpu_oe,
    output logic               src_run,
    output logic               src_oe,
    output logic               cpu_ss_on,
    output logic               src_ss_on,
    output logic               osc_en,
    output logic               vco_en,
    output logic               mn_en,
    output logic [M_W-1:0]     cpu_m,
    output logic [N_W-1:0]     cpu_n,
    output logic [M_W-1:0]     src_m,
    output logic [N_W-1:0]     src_n
);
    cfg_t               cfg;
    logic [STRAP_W-1:0] strap_lat;
    logic               strap_drv;
    logic               pd_sync;
    logic               ss_sync;
    logic               pd_act;
    logic               live;
    logic               float_grp;
    logic               vco_q;
    logic [RUN_W-1:0]   want_all;
    logic [RUN_W-1:0]   run_all;

    strap_latch #(.W(STRAP_W)) u_strap (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .lat_q(strap_lat), .drv_q(strap_drv)
    );

    ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
        .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_sync)
    );

    sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .d(spread_pin), .q(ss_sync)
    );

    // Frequency code source and the tristate decode it implies.
    always_comb begin
        fs_code   = cfg.fs_sw_src ? cfg.fs_sw : {1'b0, strap_lat};
        float_grp = (fs_code == '0);
    end

    // Requested run state for every output; nothing runs in power-down.
    always_comb begin
        pd_act   = !pd_sync;
        live     = strap_drv && !pd_act;
        want_all = {cfg.src_en, cfg.cpu_en, cfg.ref_en, cfg.usb_en, cfg.htt_en, cfg.pci_en}
                   & {RUN_W{live}};
    end

    // One phase-aligned gate per output group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int B = grp_base(g);
        out_gate #(.N(GRP_W[g])) u_gate (
            .clk(clk), .rst_n(rst_n), .phase_low(grp_low[g]),
            .want(want_all[B +: GRP_W[g]]), .run_q(run_all[B +: GRP_W[g]])
        );
    end

    // VCO starts one cycle behind the oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n) vco_q <= 1'b0;
        else        vco_q <= osc_en;
    end

    // Output mapping, drive enables, spread merge and M/N pass gate.
    always_comb begin
        pci_run   = run_all[grp_base(G_PCI) +: N_PCI];
        htt_run   = run_all[grp_base(G_HTT) +: N_HTT];
        usb_run   = run_all[grp_base(G_USB) +: N_USB];
        ref_run   = run_all[grp_base(G_REF) +: N_REF];
        cpu_run   = run_all[grp_base(G_CPU) +: N_CPU];
        src_run   = run_all[grp_base(G_SRC)];
        pci_oe    = !float_grp;
        htt_oe    = !float_grp;
        cpu_oe    = !float_grp;
        src_oe    = cfg.src_en && !(pd_act && cfg.src_pd_float);
        cpu_ss_on = ss_sync || cfg.cpu_ss;
        src_ss_on = ss_sync || cfg.src_ss;
        osc_en    = !pd_act;
        vco_en    = vco_q && !pd_act;
        strap_oe  = strap_drv;
        mn_en     = cfg.mn_en;
        cpu_m     = cfg.mn_en ? cfg.cpu_m : '0;
        cpu_n     = cfg.mn_en ? cfg.cpu_n : '0;
        src_m     = cfg.mn_en ? cfg.src_m : '0;
        src_n     = cfg.mn_en ? cfg.src_n : '0;
    end

    AST_FS_RESET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg.fs_sw[STRAP_W-1:0] == strap_lat && !cfg.fs_sw_src)); // R2
    AST_VCO_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(osc_en)); // R8
    AST_PD_STOPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && $past(!osc_en) && $past(grp_low[G_SRC])) |-> !src_run); // R6
endmodule

// File: tb/clkout_ctl_test.sv
module clkout_ctl_test;
    import clkctl_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic [STRAP_W-1:0] strap_in;
    logic               strap_oe;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;
    logic               pd_n, spread_pin;
    logic [NUM_GRP-1:0] grp_low;
    logic [FS_W-1:0]    fs_code;
    logic [3:0]         pci_run, htt_run, cpu_run;
    logic [1:0]         usb_run, ref_run;
    logic               pci_oe, htt_oe, cpu_oe, src_run, src_oe;
    logic               cpu_ss_on, src_ss_on, osc_en, vco_en, mn_en;
    logic [M_W-1:0]     cpu_m, src_m;
    logic [N_W-1:0]     cpu_n, src_n;

    clkout_ctl uut (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_oe(strap_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pd_n(pd_n), .spread_pin(spread_pin), .grp_low(grp_low),
        .fs_code(fs_code), .pci_run(pci_run), .pci_oe(pci_oe),
        .htt_run(htt_run), .htt_oe(htt_oe), .usb_run(usb_run), .ref_run(ref_run),
        .cpu_run(cpu_run), .cpu_oe(cpu_oe), .src_run(src_run), .src_oe(src_oe),
        .cpu_ss_on(cpu_ss_on), .src_ss_on(src_ss_on), .osc_en(osc_en), .vco_en(vco_en),
        .mn_en(mn_en), .cpu_m(cpu_m), .cpu_n(cpu_n), .src_m(src_m), .src_n(src_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] sh [0:10];
    logic [STRAP_W-1:0] strap_cap;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a <= 4'd10) sh[a] = d;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [3:0] e_fs();
        return sh[0][7] ? sh[0][3:0] : {1'b0, strap_cap};
    endfunction

    // Full comparison of every port against the shadow model, after settling.
    task automatic check_all(input string tag);
        logic live, fl, mn;
        live = pd_n;
        fl   = (e_fs() == 4'd0);
        mn   = sh[4][0];
        chk({"R2 fs_code ", tag}, fs_code, e_fs());
        chk({"R3 oe ", tag}, {pci_oe, htt_oe, cpu_oe}, {3{!fl}});
        chk({"R4 pci/htt ", tag}, {htt_run, pci_run}, sh[1] & {8{live}});
        chk({"R4 usb/ref ", tag}, {ref_run, usb_run}, sh[2][3:0] & {4{live}});
        chk({"R5 cpu ", tag}, cpu_run, sh[2][7:4] & {4{live}});
        chk({"R6 src ", tag}, {src_run, src_oe},
            {sh[3][0] & live, sh[3][0] & !(!live & sh[3][1])});
        chk({"R7 ss ", tag}, {cpu_ss_on, src_ss_on},
            {spread_pin | sh[0][6], spread_pin | sh[0][5]});
        chk({"R8 osc/vco ", tag}, {osc_en, vco_en}, {live, live});
        chk({"R9 mn ", tag}, {mn_en, cpu_m, cpu_n}, {mn, mn ? {sh[5][5:0], sh[7][1:0], sh[6]} : 16'h0});
        chk({"R9 mn src ", tag}, {src_m, src_n}, mn ? {sh[8][5:0], sh[10][1:0], sh[9]} : 16'h0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; strap_in = 3'b101; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pd_n = 1'b1; spread_pin = 1'b0; grp_low = '1;
        strap_cap = 3'b101;
        sh[0] = {5'b0, 3'b101}; sh[1] = 8'hFF; sh[2] = 8'hFF; sh[3] = 8'h01;
        for (int i = 4; i <= 10; i++) sh[i] = 8'h00;
        cyc(5);
        // Reset state
        chk("R1 strap_oe in reset", strap_oe, 0);
        chk("R8 osc in reset", osc_en, 0);
        chk("R4 runs in reset", {pci_run, htt_run, cpu_run, src_run}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strap_oe after release", strap_oe, 1);
        strap_in = 3'b010;
        cyc(5);
        chk("R1 strap held after pin change", fs_code, 4'b0101);
        check_all("post reset");

        // R10: run holds while low phase absent
        grp_low = '0;
        wr(A_SE_EN, 8'hF0);
        cyc(3);
        chk("R10 pci holds without low phase", pci_run, 4'hF);
        grp_low[G_PCI] = 1'b1;
        @(negedge clk);
        chk("R10 pci stops at low phase", pci_run, 4'h0);
        chk("R10 htt untouched", htt_run, 4'hF);
        grp_low = '1;
        wr(4'd13, 8'h00);
        cyc(2);
        check_all("R10 unmapped write");

        // R3: software code zero floats groups, nonzero drives them
        wr(A_FREQ, 8'h80);
        chk("R3 code zero float", {pci_oe, htt_oe, cpu_oe}, 3'b000);
        wr(A_FREQ, 8'h88);
        chk("R3 code eight driven", {fs_code, pci_oe}, {4'h8, 1'b1});
        wr(A_FREQ, 8'h00);
        chk("R2 back to strap", fs_code, 4'b0101);

        // R7: spread pin latency
        @(negedge clk); spread_pin = 1'b1;
        @(negedge clk);
        chk("R7 spread one edge", {cpu_ss_on, src_ss_on}, 2'b00);
        @(negedge clk);
        chk("R7 spread two edges", {cpu_ss_on, src_ss_on}, 2'b11);
        spread_pin = 1'b0;
        cyc(3);

        // R8: power-down latency and VCO ordering; R6 float during pd
        wr(A_SRC, 8'h03);
        @(negedge clk); pd_n = 1'b0;
        @(negedge clk);
        chk("R8 osc one edge", osc_en, 1);
        @(negedge clk);
        chk("R8 osc/vco two edges", {osc_en, vco_en}, 2'b00);
        chk("R8 runs not yet stopped", htt_run, 4'hF);
        chk("R6 src floats in pd", src_oe, 0);
        @(negedge clk);
        chk("R8 runs stopped", {htt_run, cpu_run, src_run}, 9'h0);
        pd_n = 1'b1;
        cyc(2);
        chk("R8 osc back, vco later", {osc_en, vco_en}, 2'b10);
        @(negedge clk);
        chk("R8 vco one cycle after osc", vco_en, 1);
        cyc(2);
        check_all("after pd");

        // R9: M/N gate
        wr(A_CPU_M, 8'h2A); wr(A_CPU_NL, 8'h5C); wr(A_CPU_NH, 8'h03);
        wr(A_SRC_M, 8'h11); wr(A_SRC_NL, 8'hA5); wr(A_SRC_NH, 8'h02);
        chk("R9 blocked", {cpu_m, cpu_n}, 0);
        wr(A_PLL, 8'h01);
        chk("R9 passed", {cpu_m, cpu_n}, {6'h2A, 10'h35C});

        // Random mix
        for (int it = 0; it < 80; it++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            wr(a, 8'($urandom));
            if ($urandom_range(0, 3) == 0) pd_n = ~pd_n;
            spread_pin = 1'($urandom);
            cyc(6);
            check_all("random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule